// File: doc/BRIEF.md
# Real-Time Clock Register Window

This block is the bus-side register front end of a real-time clock and calendar. A small byte bus reaches three locations: a configuration byte and two value bytes, high and low. A two-bit window pointer in the configuration byte chooses which pair of calendar fields shows through the value bytes. Each access to the high byte moves the pointer down by one, so software can sweep the whole calendar with a short run of back-to-back accesses.

Behind the window sits a BCD calendar with seconds, minutes, hours, day, month, year and weekday. An internal prescaler divides the clock into half-second phases. A phase bit, a synchronisation flag that warns of an imminent ripple, and a gated square-wave output are derived from it. Value writes and the enable bit are protected by a write-enable bit. Only a configuration write that carries the unlock strobe can set that bit.

Top module: `rtc_window`

## Requirements
- R1: Reset (rst_ni low) clears every configuration bit and sets the calendar to 00:00:00, day 01, month 01, year 00, weekday 0.
- R2: addr_i selects 0 = configuration, 1 = high value byte, 2 = low value byte; address 3 reads 0. Configuration bits: [0] enable, [1] write enable, [2] output enable, [3] sync (read-only), [4] half-second (read-only), [5] reads 0, [7:6] window pointer.
- R3: A configuration write sets write enable to bit 1 of the data only when unlock_i is high in the same cycle; without unlock_i a write can clear it but never set it.
- R4: A configuration write changes the enable bit only if write enable was already 1 before that write.
- R5: While write enable is 0, writes to either value byte leave the calendar unchanged; while it is 1, they load the field that the pointer selects.
- R6: Each read or write of the high byte decrements the pointer by one, and the pointer holds at 0. Low-byte accesses leave the pointer unchanged.
- R7: High byte by pointer: 0 minutes, 1 weekday, 2 month, 3 reads 0 and is not writable. Low byte: 0 seconds, 1 hours, 2 day, 3 year.
- R8: While enabled, the half-second bit is 0 for HALF_CYC cycles and then 1 for HALF_CYC cycles. A write of the seconds field clears it and restarts the phase.
- R9: The seconds field advances when the half-second bit falls. All fields are BCD. Seconds and minutes wrap after 59, hours after 23, weekday after 6, month from 12 to 01, and year after 99. The last day is 31, 30 for months 04/06/09/11, and 28 for month 02, or 29 when the year is divisible by 4.
- R10: The sync bit is 1 during the last SYNC_CYC cycles before each seconds increment and is 0 once the increment has been applied.
- R11: clk_o equals the half-second bit when output enable is 1, and is 0 otherwise.
- R12: While the enable bit is 0, the calendar and the half-second phase hold their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous power-on reset |
| rd_i | input | 1 | Read strobe for the addressed location |
| wr_i | input | 1 | Write strobe for the addressed location |
| addr_i | input | 2 | Location select |
| wdata_i | input | 8 | Write data |
| unlock_i | input | 1 | Unlock strobe, qualifies a configuration write |
| rdata_o | output | 8 | Read data for addr_i (combinational) |
| clk_o | output | 1 | Gated half-second square wave |

## Verification
The bench builds the block with HALF_CYC = 8 and SYNC_CYC = 3, so one second lasts 16 cycles. This lets each calendar rollover be reached after a single preload, and lets the phase and sync edges be sampled at exact cycle counts. Preloading a field sequence just before a rollover makes the leap-year, 30-day, year-end and weekday wraps take a few dozen cycles each, instead of a simulated year.

// File: rtl/rtc_win_pkg.sv
package rtc_win_pkg;

  localparam int FW = 8;  // BCD field width

  typedef struct packed {
    logic [FW-1:0] sec;
    logic [FW-1:0] min;
    logic [FW-1:0] hour;
    logic [FW-1:0] day;
    logic [FW-1:0] mon;
    logic [FW-1:0] year;
    logic [FW-1:0] wday;
  } rtc_time_t;

  // configuration bit positions
  localparam int CB_EN   = 0;
  localparam int CB_WREN = 1;
  localparam int CB_OE   = 2;
  localparam int CB_SYNC = 3;
  localparam int CB_HALF = 4;
  localparam int CB_PTR  = 6;

  function automatic logic [FW-1:0] bcd_inc(input logic [FW-1:0] v);
    if (v[3:0] == 4'd9) return {v[7:4] + 4'd1, 4'd0};
    return v + 8'd1;
  endfunction

  function automatic logic is_leap(input logic [FW-1:0] y);
    logic [5:0] s;
    s = {1'b0, y[7:4], 1'b0} + {2'b0, y[3:0]};  // (2*tens + ones) mod 4
    return s[1:0] == 2'd0;
  endfunction

  function automatic logic [FW-1:0] last_day(input logic [FW-1:0] m, input logic [FW-1:0] y);
    case (m)
      8'h02:                      return is_leap(y) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction

endpackage

// File: rtl/rtc_prescale.sv
module rtc_prescale #(
  parameter int HALF_CYC = 16384,
  parameter int SYNC_CYC = 32
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic clr_i,
  output logic half_o,
  output logic sync_o,
  output logic tick_o
);
  localparam int CW = (HALF_CYC > 2) ? $clog2(HALF_CYC) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF_CYC - 1);
  localparam logic [CW-1:0] SYNC_FROM = CW'(HALF_CYC - SYNC_CYC);

  logic [CW-1:0] cnt_q;
  logic          half_q;
  logic          wrap;

  assign wrap   = en_i && (cnt_q == LAST);
  assign tick_o = wrap && half_q;
  assign sync_o = en_i && half_q && (cnt_q >= SYNC_FROM);
  assign half_o = half_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      half_q <= 1'b0;
    end else if (clr_i) begin
      cnt_q  <= '0;
      half_q <= 1'b0;
    end else if (wrap) begin
      cnt_q  <= '0;
      half_q <= ~half_q;
    end else if (en_i) begin
      cnt_q  <= cnt_q + 1'b1;
    end
  end

  p_frozen_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i && !clr_i |=> $stable(half_q) && $stable(cnt_q));
  p_tick_in_sync_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |-> sync_o);
  p_tick_drops_half_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> !half_q);

endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar
  import rtc_win_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          wr_hi_i,
  input  logic          wr_lo_i,
  input  logic [1:0]    sel_i,
  input  logic [FW-1:0] wdata_i,
  output rtc_time_t     time_o
);
  rtc_time_t q, n;

  always_comb begin
    n = q;
    if (tick_i) begin
      if (q.sec == 8'h59) begin
        n.sec = 8'h00;
        if (q.min == 8'h59) begin
          n.min = 8'h00;
          if (q.hour == 8'h23) begin
            n.hour = 8'h00;
            n.wday = (q.wday == 8'h06) ? 8'h00 : q.wday + 8'd1;
            if (q.day == last_day(q.mon, q.year)) begin
              n.day = 8'h01;
              if (q.mon == 8'h12) begin
                n.mon  = 8'h01;
                n.year = (q.year == 8'h99) ? 8'h00 : bcd_inc(q.year);
              end else begin
                n.mon = bcd_inc(q.mon);
              end
            end else begin
              n.day = bcd_inc(q.day);
            end
          end else begin
            n.hour = bcd_inc(q.hour);
          end
        end else begin
          n.min = bcd_inc(q.min);
        end
      end else begin
        n.sec = bcd_inc(q.sec);
      end
    end
    if (wr_lo_i) begin
      case (sel_i)
        2'd0: n.sec  = wdata_i;
        2'd1: n.hour = wdata_i;
        2'd2: n.day  = wdata_i;
        default: n.year = wdata_i;
      endcase
    end
    if (wr_hi_i) begin
      case (sel_i)
        2'd0: n.min  = wdata_i;
        2'd1: n.wday = wdata_i;
        2'd2: n.mon  = wdata_i;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q <= '{sec: 8'h00, min: 8'h00, hour: 8'h00, day: 8'h01,
             mon: 8'h01, year: 8'h00, wday: 8'h00};
    end else begin
      q <= n;
    end
  end

  assign time_o = q;

  p_sec_moves_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i && !wr_lo_i |=> q.sec != $past(q.sec));
  p_idle_hold_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i && !wr_lo_i && !wr_hi_i |=> $stable(q));

endmodule

// File: rtl/rtc_window.sv
module rtc_window
  import rtc_win_pkg::*;
#(
  parameter int HALF_CYC = 16384,
  parameter int SYNC_CYC = 32
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       rd_i,
  input  logic       wr_i,
  input  logic [1:0] addr_i,
  input  logic [7:0] wdata_i,
  input  logic       unlock_i,
  output logic [7:0] rdata_o,
  output logic       clk_o
);
  localparam logic [1:0] A_CFG = 2'd0;
  localparam logic [1:0] A_HI  = 2'd1;
  localparam logic [1:0] A_LO  = 2'd2;

  logic       en_q, wren_q, oe_q;
  logic [1:0] ptr_q;
  logic       cfg_wr, hi_acc, wr_hi, wr_lo;
  logic       half, sync, tick;
  rtc_time_t  tm;

  assign cfg_wr = wr_i && (addr_i == A_CFG);
  assign hi_acc = (rd_i || wr_i) && (addr_i == A_HI);
  assign wr_hi  = wr_i && (addr_i == A_HI) && wren_q;
  assign wr_lo  = wr_i && (addr_i == A_LO) && wren_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= 1'b0;
      wren_q <= 1'b0;
      oe_q   <= 1'b0;
      ptr_q  <= 2'd0;
    end else if (cfg_wr) begin
      wren_q <= unlock_i ? wdata_i[CB_WREN] : (wren_q & wdata_i[CB_WREN]);
      if (wren_q) en_q <= wdata_i[CB_EN];
      oe_q   <= wdata_i[CB_OE];
      ptr_q  <= wdata_i[CB_PTR +: 2];
    end else if (hi_acc && ptr_q != 2'd0) begin
      ptr_q  <= ptr_q - 2'd1;
    end
  end

  rtc_prescale #(.HALF_CYC(HALF_CYC), .SYNC_CYC(SYNC_CYC)) u_pre (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (en_q),
    .clr_i (wr_lo && ptr_q == 2'd0),
    .half_o(half),
    .sync_o(sync),
    .tick_o(tick)
  );

  rtc_calendar u_cal (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (tick),
    .wr_hi_i(wr_hi),
    .wr_lo_i(wr_lo),
    .sel_i  (ptr_q),
    .wdata_i(wdata_i),
    .time_o (tm)
  );

  always_comb begin
    rdata_o = 8'h00;
    case (addr_i)
      A_CFG: begin
        rdata_o[CB_EN]        = en_q;
        rdata_o[CB_WREN]      = wren_q;
        rdata_o[CB_OE]        = oe_q;
        rdata_o[CB_SYNC]      = sync;
        rdata_o[CB_HALF]      = half;
        rdata_o[CB_PTR +: 2]  = ptr_q;
      end
      A_HI: case (ptr_q)
        2'd0: rdata_o = tm.min;
        2'd1: rdata_o = tm.wday;
        2'd2: rdata_o = tm.mon;
        default: rdata_o = 8'h00;
      endcase
      A_LO: case (ptr_q)
        2'd0: rdata_o = tm.sec;
        2'd1: rdata_o = tm.hour;
        2'd2: rdata_o = tm.day;
        default: rdata_o = tm.year;
      endcase
      default: rdata_o = 8'h00;
    endcase
  end

  assign clk_o = oe_q & half;

  p_wren_lock_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wren_q && !(cfg_wr && unlock_i) |=> !wren_q);
  p_en_gate_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wren_q |=> $stable(en_q));
  p_locked_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wren_q && !tick |=> $stable(tm));
  p_ptr_step_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hi_acc && ptr_q != 2'd0 |=> ptr_q == $past(ptr_q) - 2'd1);
  p_ptr_floor_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ptr_q == 2'd0 && !cfg_wr |=> ptr_q == 2'd0);
  p_clk_gate_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !oe_q |-> !clk_o);

endmodule

// File: tb/rtc_window_test.sv
module rtc_window_test;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       rd_i = 1'b0, wr_i = 1'b0, unlock_i = 1'b0;
  logic [1:0] addr_i = 2'd0;
  logic [7:0] wdata_i = 8'h00;
  logic [7:0] rdata_o;
  logic       clk_o;
  int total = 0, bad = 0;

  always #2.5 clk = ~clk;

  rtc_window #(.HALF_CYC(8), .SYNC_CYC(3)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .rd_i(rd_i), .wr_i(wr_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .unlock_i(unlock_i), .rdata_o(rdata_o), .clk_o(clk_o)
  );

  // start {yr,mo,dy,hr,wd} at xx:59:59 -> expected {yr,mo,dy,hr,wd} at :00:00
  localparam int NV = 8;
  localparam logic [79:0] VEC [NV] = '{
    {8'h24,8'h02,8'h28,8'h23,8'h03, 8'h24,8'h02,8'h29,8'h00,8'h04},
    {8'h23,8'h02,8'h28,8'h23,8'h06, 8'h23,8'h03,8'h01,8'h00,8'h00},
    {8'h24,8'h04,8'h30,8'h23,8'h01, 8'h24,8'h05,8'h01,8'h00,8'h02},
    {8'h99,8'h12,8'h31,8'h23,8'h05, 8'h00,8'h01,8'h01,8'h00,8'h06},
    {8'h24,8'h02,8'h29,8'h23,8'h02, 8'h24,8'h03,8'h01,8'h00,8'h03},
    {8'h25,8'h01,8'h31,8'h23,8'h00, 8'h25,8'h02,8'h01,8'h00,8'h01},
    {8'h00,8'h02,8'h28,8'h23,8'h04, 8'h00,8'h02,8'h29,8'h00,8'h05},
    {8'h24,8'h06,8'h15,8'h09,8'h03, 8'h24,8'h06,8'h15,8'h10,8'h03}
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d, input logic unl);
    @(negedge clk);
    addr_i = a; wdata_i = d; unlock_i = unl; wr_i = 1'b1;
    @(negedge clk);
    wr_i = 1'b0; unlock_i = 1'b0; addr_i = 2'd0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    addr_i = a; rd_i = 1'b1;
    #1 d = rdata_o;
    @(negedge clk);
    rd_i = 1'b0; addr_i = 2'd0;
  endtask

  task automatic peek(input logic [1:0] a, output logic [7:0] d);
    addr_i = a;
    #1 d = rdata_o;
    addr_i = 2'd0;
  endtask

  task automatic edges(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary;
    $display("  test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    summary();
    $finish;
  end

  initial begin
    logic [7:0] v;
    edges(3);
    rst_ni = 1'b1;
    edges(1);

    // R1 reset state
    peek(2'd0, v); chk("R1 cfg", v, 8'h00);
    peek(2'd2, v); chk("R1 sec", v, 8'h00);
    peek(2'd3, v); chk("R2 addr3", v, 8'h00);

    // R5 locked value write, R3 set without unlock, R4 enable while locked
    wr(2'd2, 8'h42, 1'b0);
    peek(2'd2, v); chk("R5 locked", v, 8'h00);
    wr(2'd0, 8'h02, 1'b0);
    peek(2'd0, v); chk("R3 no unlock", v, 8'h00);
    wr(2'd0, 8'h01, 1'b0);
    peek(2'd0, v); chk("R4 en locked", v, 8'h00);
    wr(2'd0, 8'h03, 1'b1);
    peek(2'd0, v); chk("R3 unlock", v, 8'h02);

    // table of rollovers (R5 R6 R7 R9)
    for (int i = 0; i < NV; i++) begin
      logic [79:0] e;
      e = VEC[i];
      wr(2'd0, 8'hC2, 1'b0);
      wr(2'd2, e[79:72], 1'b0);
      wr(2'd1, 8'hEE, 1'b0);
      wr(2'd2, e[63:56], 1'b0);
      wr(2'd1, e[71:64], 1'b0);
      wr(2'd2, e[55:48], 1'b0);
      wr(2'd1, e[47:40], 1'b0);
      wr(2'd2, 8'h59, 1'b0);
      wr(2'd1, 8'h59, 1'b0);
      wr(2'd0, 8'h03, 1'b0);
      wr(2'd2, 8'h59, 1'b0);
      edges(16);
      wr(2'd0, 8'hC2, 1'b0);
      rd(2'd2, v); chk("R9 year", v, e[39:32]);
      rd(2'd1, v); chk("R7 reserved", v, 8'h00);
      peek(2'd0, v); chk("R6 ptr step", {6'd0, v[7:6]}, 8'h02);
      rd(2'd2, v); chk("R9 day", v, e[23:16]);
      rd(2'd1, v); chk("R9 month", v, e[31:24]);
      rd(2'd2, v); chk("R9 hour", v, e[15:8]);
      rd(2'd1, v); chk("R9 wday", v, e[7:0]);
      rd(2'd2, v); chk("R9 sec", v, 8'h00);
      rd(2'd1, v); chk("R9 min", v, 8'h00);
      peek(2'd0, v); chk("R6 ptr floor", {6'd0, v[7:6]}, 8'h00);
    end

    // phase, sync and output (R8 R10 R11)
    wr(2'd0, 8'h07, 1'b0);
    wr(2'd2, 8'h10, 1'b0);
    edges(7);
    peek(2'd0, v); chk("R8 half low", {7'd0, v[4]}, 8'h00);
    chk("R11 clk low", {7'd0, clk_o}, 8'h00);
    edges(1);
    peek(2'd0, v); chk("R8 half high", {7'd0, v[4]}, 8'h01);
    chk("R11 clk high", {7'd0, clk_o}, 8'h01);
    edges(4);
    peek(2'd0, v); chk("R10 sync early", {7'd0, v[3]}, 8'h00);
    edges(1);
    peek(2'd0, v); chk("R10 sync on", {7'd0, v[3]}, 8'h01);
    edges(2);
    peek(2'd0, v); chk("R10 sync last", {7'd0, v[3]}, 8'h01);
    peek(2'd2, v); chk("R10 sec before", v, 8'h10);
    edges(1);
    peek(2'd0, v); chk("R10 sync off", {7'd0, v[3]}, 8'h00);
    chk("R8 half fell", {7'd0, v[4]}, 8'h00);
    peek(2'd2, v); chk("R9 sec step", v, 8'h11);
    edges(8);
    wr(2'd0, 8'h03, 1'b0);
    peek(2'd0, v); chk("R8 half set", {7'd0, v[4]}, 8'h01);
    chk("R11 oe off", {7'd0, clk_o}, 8'h00);
    wr(2'd2, 8'h30, 1'b0);
    peek(2'd0, v); chk("R8 sec write clears", {7'd0, v[4]}, 8'h00);

    // R12 frozen while disabled
    wr(2'd0, 8'h02, 1'b0);
    edges(40);
    peek(2'd2, v); chk("R12 sec hold", v, 8'h30);
    peek(2'd0, v); chk("R12 half hold", {7'd0, v[4]}, 8'h00);

    // R1 power-on reset again
    wr(2'd0, 8'h43, 1'b0);
    rst_ni = 1'b0;
    edges(2);
    rst_ni = 1'b1;
    edges(1);
    peek(2'd0, v); chk("R1 cfg por", v, 8'h00);
    peek(2'd2, v); chk("R1 sec por", v, 8'h00);

    summary();
    $finish;
  end
endmodule